// File: doc/BRIEF.md
# Staircase-Ramp ADC Conversion Controller

This block sequences the digital half of a counting-type analog-to-digital converter. A start request clears a binary step counter, whose value drives an external DAC, so the DAC output drops to zero. The block then waits a fixed number of settling cycles. After that it raises an internal run state, and in that state the counter steps up by one on every clock, so the DAC output climbs as a staircase.

An external comparator reports through a single bit when the staircase has passed the analog input. At the first cycle that bit is seen high while running, the block stops counting, freezes the counter and captures the counter value as the conversion result. It then gives a single-cycle done pulse. Because every conversion climbs again from zero, the conversion time grows with the input level. If the counter reaches its top code and the comparator never fires, the conversion ends with an over-range flag.

Top module: `ramp_adc_ctrl`

## Requirements
- R1: During and right after reset, the DAC code, result, busy, done and over-range outputs are all zero.
- R2: A start request sampled while idle sets the DAC code to 0 and raises busy in the next cycle.
- R3: After the start edge, the DAC code stays at 0 for SETTLE_CYC more clock edges. The first increment comes at edge SETTLE_CYC+1.
- R4: While running, the DAC code rises by exactly one per clock. It never falls until the next start.
- R5: Running stops at the first edge that samples the comparator high. That edge freezes the DAC code, copies it to the result, and raises done for exactly one cycle while busy falls.
- R6: For a comparator that goes high once the code exceeds an input level v, where v is below the top code, done rises SETTLE_CYC+v+2 edges after the start edge and the result is v+1.
- R7: If the code reaches all ones with the comparator low, the next edge ends the conversion. Done rises SETTLE_CYC+2^CODE_W edges after start, the result is all ones, and the over-range flag goes high and stays high until the next accepted start clears it.
- R8: A comparator seen high at the all-ones code ends the conversion normally, with the over-range flag low.
- R9: A start request while busy is ignored. The count, the timing and the result stay the same.
- R10: Between conversions, the result and the DAC code hold their values.
- R11: The comparator bit has no effect before the run state begins. A high level during settling does not shorten the conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Conversion request, sampled while idle |
| cmp_above_i | input | 1 | Comparator: staircase is above the analog input |
| dac_code_o | output | CODE_W | Step counter value driving the DAC |
| result_o | output | CODE_W | Result of the last conversion |
| busy_o | output | 1 | Conversion in progress (settling or running) |
| done_o | output | 1 | One-cycle end-of-conversion pulse |
| overrange_o | output | 1 | Last conversion reached full scale without a crossing |

## Verification
The hardest case to reach is the end of the scale: a conversion that runs to the all-ones code with no crossing, next to one whose crossing happens exactly at that code. The bench reaches both by sweeping a modelled input level over every code of a 5-bit configuration, with the comparator computed from the live DAC code. Start requests in the middle of a run, and a comparator held high during settling, are added to chosen conversions. The expected latency and result are worked out arithmetically from the input level.

// File: rtl/ramp_adc_pkg.sv
package ramp_adc_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETTLE = 2'd1,
    PH_RUN    = 2'd2
  } phase_t;
endpackage

// File: rtl/ramp_settle_timer.sv
module ramp_settle_timer #(
  parameter int SETTLE_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clear_i,
  input  logic tick_i,
  output logic expired_o
);
  localparam int TW = (SETTLE_CYC < 2) ? 1 : $clog2(SETTLE_CYC + 1);
  localparam logic [TW-1:0] LAST = TW'(SETTLE_CYC - 1);

  logic [TW-1:0] cnt_q;

  assign expired_o = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (clear_i) begin
      cnt_q <= '0;
    end else if (tick_i && !expired_o) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/ramp_step_counter.sv
module ramp_step_counter #(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear_i,
  input  logic              inc_i,
  output logic [CODE_W-1:0] count_o,
  output logic              at_max_o
);
  logic [CODE_W-1:0] cnt_q;

  assign count_o  = cnt_q;
  assign at_max_o = &cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (clear_i) begin
      cnt_q <= '0;
    end else if (inc_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/ramp_seq_ctrl.sv
module ramp_seq_ctrl #(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              cmp_above_i,
  input  logic              settle_done_i,
  input  logic [CODE_W-1:0] count_i,
  input  logic              at_max_i,
  output logic              clear_o,
  output logic              tick_o,
  output logic              inc_o,
  output logic [CODE_W-1:0] result_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              overrange_o
);
  import ramp_adc_pkg::*;

  phase_t            phase_q;
  logic [CODE_W-1:0] result_q;
  logic              done_q;
  logic              ovr_q;

  // Crossing has priority over reaching full scale.
  assign clear_o = (phase_q == PH_IDLE) && start_i;
  assign tick_o  = (phase_q == PH_SETTLE);
  assign inc_o   = (phase_q == PH_RUN) && !cmp_above_i && !at_max_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= PH_IDLE;
      result_q <= '0;
      done_q   <= 1'b0;
      ovr_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (phase_q)
        PH_IDLE: begin
          if (start_i) begin
            phase_q <= PH_SETTLE;
            ovr_q   <= 1'b0;
          end
        end
        PH_SETTLE: begin
          if (settle_done_i) phase_q <= PH_RUN;
        end
        PH_RUN: begin
          if (cmp_above_i) begin
            phase_q  <= PH_IDLE;
            done_q   <= 1'b1;
            result_q <= count_i;
          end else if (at_max_i) begin
            phase_q  <= PH_IDLE;
            done_q   <= 1'b1;
            ovr_q    <= 1'b1;
            result_q <= count_i;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign result_o    = result_q;
  assign busy_o      = (phase_q != PH_IDLE);
  assign done_o      = done_q;
  assign overrange_o = ovr_q;
endmodule

// File: rtl/ramp_adc_ctrl.sv
module ramp_adc_ctrl #(
  parameter int CODE_W     = 8,
  parameter int SETTLE_CYC = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              cmp_above_i,
  output logic [CODE_W-1:0] dac_code_o,
  output logic [CODE_W-1:0] result_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              overrange_o
);
  logic clr_w, tick_w, inc_w, settle_done_w, at_max_w;
  logic [CODE_W-1:0] count_w;

  ramp_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
    .clk(clk), .rst(rst), .clear_i(clr_w), .tick_i(tick_w),
    .expired_o(settle_done_w)
  );

  ramp_step_counter #(.CODE_W(CODE_W)) u_count (
    .clk(clk), .rst(rst), .clear_i(clr_w), .inc_i(inc_w),
    .count_o(count_w), .at_max_o(at_max_w)
  );

  ramp_seq_ctrl #(.CODE_W(CODE_W)) u_seq (
    .clk(clk), .rst(rst), .start_i(start_i), .cmp_above_i(cmp_above_i),
    .settle_done_i(settle_done_w), .count_i(count_w), .at_max_i(at_max_w),
    .clear_o(clr_w), .tick_o(tick_w), .inc_o(inc_w),
    .result_o(result_o), .busy_o(busy_o), .done_o(done_o),
    .overrange_o(overrange_o)
  );

  assign dac_code_o = count_w;
endmodule

// File: rtl/ramp_adc_ctrl_chk.sv
module ramp_adc_ctrl_chk #(
  parameter int CODE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [CODE_W-1:0] dac_code_o,
  input logic [CODE_W-1:0] result_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              overrange_o
);
  // R5: done lasts a single cycle
  assert_done_single_R5: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R5: done only ends a conversion that was in progress
  assert_done_after_busy_R5: assert property (@(posedge clk) disable iff (rst)
    done_o |-> ($past(busy_o) && !busy_o));

  // R4, R9: code only steps up by one while busy
  assert_step_by_one_R4: assert property (@(posedge clk) disable iff (rst)
    (busy_o && $past(busy_o)) |->
      (dac_code_o == $past(dac_code_o) || dac_code_o == $past(dac_code_o) + 1'b1));

  // R5: result equals frozen code at done
  assert_result_matches_code_R5: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (result_o == dac_code_o));

  // R7: over-range end leaves the code at full scale
  assert_overrange_full_R7: assert property (@(posedge clk) disable iff (rst)
    (done_o && overrange_o) |-> (&dac_code_o));

  // R10: result changes only with done
  assert_result_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(result_o));

  // R10: code holds while idle without a new start
  assert_code_hold_idle_R10: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !$past(busy_o)) |-> $stable(dac_code_o));
endmodule

bind ramp_adc_ctrl ramp_adc_ctrl_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst(rst), .dac_code_o(dac_code_o), .result_o(result_o),
  .busy_o(busy_o), .done_o(done_o), .overrange_o(overrange_o)
);

// File: tb/tb_ramp_adc_ctrl.sv
`timescale 1ns/1ps
module tb_ramp_adc_ctrl;
  localparam int W    = 5;
  localparam int S    = 3;
  localparam int TOP  = (1 << W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic force_hi = 1'b0;
  int   vin = 0;
  logic cmp;
  logic [W-1:0] dac, res;
  logic busy, done, ovr;
  int n_checks = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  // Modelled comparator: staircase above the input level.
  assign cmp = force_hi | (int'(dac) > vin);

  ramp_adc_ctrl #(.CODE_W(W), .SETTLE_CYC(S)) dut (
    .clk(clk), .rst(rst), .start_i(start), .cmp_above_i(cmp),
    .dac_code_o(dac), .result_o(res), .busy_o(busy), .done_o(done),
    .overrange_o(ovr)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic convert(input int level, input bit glitch, input bit settle_hi);
    int n = 0;
    int exp_n;
    int exp_res;
    bit ramp_ok = 1'b1;
    bit settle_ok = 1'b1;
    bit seen = 1'b0;
    vin = level;
    exp_n   = (level < TOP) ? S + level + 2 : S + TOP + 1;
    exp_res = (level < TOP) ? level + 1 : TOP;
    @(negedge clk) start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    check(busy == 1'b1 && dac == '0 && ovr == 1'b0, "R2", int'(dac), 0);
    if (settle_hi) force_hi = 1'b1;
    while (!seen && n < S + TOP + 20) begin
      @(posedge clk); #1;
      n++;
      if (n == S) force_hi = 1'b0;
      if (glitch && n == S + 2) start = 1'b1;
      if (glitch && n == S + 3) start = 1'b0;
      if (n <= S && dac != '0) settle_ok = 1'b0;
      if (done) seen = 1'b1;
      else if (n > S && int'(dac) != n - S) ramp_ok = 1'b0;
    end
    start = 1'b0;
    check(settle_ok, settle_hi ? "R3/R11" : "R3", n, exp_n);
    check(ramp_ok, glitch ? "R4/R9" : "R4", int'(dac), n - S - 1);
    check(seen && n == exp_n, (level < TOP) ? "R6" : "R7", n, exp_n);
    check(int'(res) == exp_res, (level == TOP - 1) ? "R8" : "R5", int'(res), exp_res);
    check(ovr == (level == TOP), (level == TOP) ? "R7" : "R8", int'(ovr), int'(level == TOP));
    @(posedge clk); #1;
    check(!done && !busy, "R5", int'(done), 0);
    repeat (3) @(posedge clk);
    #1;
    check(int'(res) == exp_res && int'(dac) == exp_res, "R10", int'(res), exp_res);
  endtask

  initial begin
    #(5.0 * 200000);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(dac == '0 && res == '0 && !busy && !done && !ovr, "R1", int'(dac), 0);
    @(negedge clk) rst = 1'b0;
    @(posedge clk); #1;
    check(dac == '0 && res == '0 && !busy && !done && !ovr, "R1", int'(res), 0);
    // Sweep every input level, including the top-code cases (R7, R8).
    for (int v = 0; v <= TOP; v++) convert(v, 1'b0, 1'b0);
    // Over-range flag cleared by next accepted start (R7).
    convert(TOP, 1'b0, 1'b0);
    @(negedge clk) start = 1'b1; vin = 2;
    @(posedge clk); #1 start = 1'b0;
    check(!ovr, "R7", int'(ovr), 0);
    while (!done) begin @(posedge clk); #1; end
    // Start while busy ignored (R9), comparator during settling ignored (R11).
    convert(7, 1'b1, 1'b0);
    convert(20, 1'b1, 1'b0);
    convert(0, 1'b0, 1'b1);
    convert(12, 1'b1, 1'b1);
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule